// File: doc/BRIEF.md
# Vectored Interrupt Controller

This controller collects 64 level-sensitive interrupt lines and routes each one to either a normal or a fast request output, based on a per-line routing bit. Software manages it through a 32-bit register bus with separate read and write strobes. Through that bus it can enable lines one at a time by number or a whole word at a time. It can also force lines active, assign each line a 4-bit priority, and set a priority threshold for the normal path. It can read back the raw line levels and the pending sets, and it can read the vector of the line that should be serviced next.

Each per-line register is split into two 32-bit words. The low word holds lines 0–31 and the high word holds lines 32–63; bit i of the high word is line 32+i.

On the normal path, an arbiter selects the pending line with the highest priority. On the fast path, the selection is simply the highest-numbered pending line. When nothing qualifies, either vector register reads all ones in its number field. A handler acknowledges a level-sensitive line by clearing that line's enable bit.

Top module: `irq_vic`

## Requirements
- R1: After reset, the control word is 0, the threshold register reads 0x1F, and all enable, routing, force and priority bits are 0. Both request outputs are low.
- R2: The byte offsets (high/low pairs) are as follows. Bit i of a low word is line i, and bit i of a high word is line 32+i.
  - control 0x00, threshold 0x04, enable-by-number 0x08, disable-by-number 0x0C
  - enable 0x10/0x14, routing 0x18/0x1C
  - normal vector 0x40, fast vector 0x44
  - raw line level 0x48/0x4C, force 0x50/0x54
  - normal pending 0x58/0x5C, fast pending 0x60/0x64
- R3: A write of n to 0x08 sets the enable bit of line n, where n is wdata bits 5:0. A write of n to 0x0C clears it. No other enable bit changes. Clearing an enable bit is the acknowledge for that line.
- R4: A line is pending while (raw level OR force bit) AND enable bit is 1. Pending follows the raw level with no latching. Normal pending lists the pending lines whose routing bit is 0, and fast pending lists those whose routing bit is 1.
- R5: A routing bit of 1 sends its line to the fast path. `firq_o` is high exactly when at least one fast-pending bit is set.
- R6: Priority word n (n = 0..7) sits at offset 0x20 + 4*(7-n). It holds the 4-bit priorities of lines 8n..8n+7, with line 8n+k in bits 4k+3:4k.
- R7: The normal vector at 0x40 returns the selected line number in bits 31:16 and that line's priority in bits 15:0. The selected line is the normal-pending line with the highest priority, with ties going to the higher line number. When no line is selected, the register reads 0xFFFF0000.
- R8: The threshold register (5 bits) controls priority masking. While its bit 4 is 1, no masking applies. While bit 4 is 0, the selected line counts only if its priority is strictly above bits 3:0; otherwise the normal vector reads 0xFFFF0000.
- R9: The fast vector at 0x44 returns the highest-numbered fast-pending line in bits 31:16, with bits 15:0 zero. When no line is fast-pending, it reads 0xFFFF0000.
- R10: `nirq_o` is high exactly when the normal vector holds a valid line number.
- R11: The control word reads back what was written.
  - Writes to the vector, raw-level and pending offsets are ignored.
  - Reads return 0 when `rd_en_i` is low, when the offset is unmapped, or when the offset is misaligned (bits 1:0 not 00). Misaligned writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 7 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| src_i | input | 64 | Level-sensitive interrupt lines |
| nirq_o | output | 1 | Normal interrupt request |
| firq_o | output | 1 | Fast interrupt request |

## Verification
Register state feeds the request outputs and the vector words combinationally. As a result, a wrong enable, routing, force or priority bit shows up in the same cycle as a read of 0x40 or 0x44 and as a change on `nirq_o` or `firq_o`, starting from the clock edge after the faulty write.

A wrong tie-break, a reversed priority word order or an off-by-one threshold compare only shows under specific patterns. These are equal priorities, a line in an upper priority word, and a selected priority equal to the threshold, so the vectors target exactly those cases. A wrong number-addressed update shows up as a neighbouring enable bit that changed, which a read of the enable word exposes at once.

// File: rtl/irq_vic_pkg.sv
package irq_vic_pkg;
  localparam int unsigned NSRC    = 64;
  localparam int unsigned PRIO_W  = 4;
  localparam int unsigned DW      = 32;
  localparam int unsigned IDX_W   = $clog2(NSRC);
  localparam int unsigned NPRIO_R = NSRC * PRIO_W / DW;

  typedef logic [4:0] word_t;

  // word index = byte offset >> 2
  localparam word_t W_CTRL   = 5'd0;
  localparam word_t W_MASK   = 5'd1;
  localparam word_t W_ENNUM  = 5'd2;
  localparam word_t W_DISNUM = 5'd3;
  localparam word_t W_ENH    = 5'd4;
  localparam word_t W_ENL    = 5'd5;
  localparam word_t W_TYPH   = 5'd6;
  localparam word_t W_TYPL   = 5'd7;
  localparam word_t W_PRITOP = 5'd15;  // priority word n at W_PRITOP - n
  localparam word_t W_NVEC   = 5'd16;
  localparam word_t W_FVEC   = 5'd17;
  localparam word_t W_SRCH   = 5'd18;
  localparam word_t W_SRCL   = 5'd19;
  localparam word_t W_FRCH   = 5'd20;
  localparam word_t W_FRCL   = 5'd21;
  localparam word_t W_NPH    = 5'd22;
  localparam word_t W_NPL    = 5'd23;
  localparam word_t W_FPH    = 5'd24;
  localparam word_t W_FPL    = 5'd25;

  localparam logic [15:0] NO_VEC   = 16'hFFFF;
  localparam logic [4:0]  MASK_RST = 5'h1F;
endpackage

// File: rtl/irq_vic_regs.sv
module irq_vic_regs
  import irq_vic_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  word_t                   word_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [DW-1:0]           ctrl_o,
  output logic [4:0]              mask_o,
  output logic [NSRC-1:0]         en_o,
  output logic [NSRC-1:0]         type_o,
  output logic [NSRC-1:0]         force_o,
  output logic [NSRC*PRIO_W-1:0]  prio_o
);
  localparam int unsigned HALF = NSRC / 2;

  logic [IDX_W-1:0] num;
  assign num = wdata_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= '0;
      mask_o  <= MASK_RST;
      en_o    <= '0;
      type_o  <= '0;
      force_o <= '0;
    end else if (wr_en_i) begin
      case (word_i)
        W_CTRL:   ctrl_o             <= wdata_i;
        W_MASK:   mask_o             <= wdata_i[4:0];
        W_ENNUM:  en_o[num]          <= 1'b1;
        W_DISNUM: en_o[num]          <= 1'b0;
        W_ENH:    en_o[NSRC-1:HALF]  <= wdata_i;
        W_ENL:    en_o[HALF-1:0]     <= wdata_i;
        W_TYPH:   type_o[NSRC-1:HALF] <= wdata_i;
        W_TYPL:   type_o[HALF-1:0]   <= wdata_i;
        W_FRCH:   force_o[NSRC-1:HALF] <= wdata_i;
        W_FRCL:   force_o[HALF-1:0]  <= wdata_i;
        default: ;
      endcase
    end
  end

  for (genvar r = 0; r < NPRIO_R; r++) begin : g_prio
    localparam word_t RW = word_t'(W_PRITOP - r);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      prio_o[r*DW +: DW] <= '0;
      else if (wr_en_i && word_i == RW) prio_o[r*DW +: DW] <= wdata_i;
    end
  end
endmodule

// File: rtl/irq_vic_arb.sv
// Highest priority wins; equal priority goes to the higher index.
module irq_vic_arb #(
  parameter int unsigned N  = 64,
  parameter int unsigned PW = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]    req_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            valid_o,
  output logic [IW-1:0]   idx_o,
  output logic [PW-1:0]   prio_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && (!valid_o || prio_i[i*PW +: PW] >= prio_o)) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
        prio_o  = prio_i[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/irq_vic_hipick.sv
// Highest-numbered set bit.
module irq_vic_hipick #(
  parameter int unsigned N = 64,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vic.sv
module irq_vic
  import irq_vic_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [6:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [NSRC-1:0] src_i,
  output logic            nirq_o,
  output logic            firq_o
);
  localparam int unsigned HALF  = NSRC / 2;
  localparam int unsigned VPAD  = 16 - IDX_W;
  localparam int unsigned PPAD  = 16 - PRIO_W;

  word_t                  word;
  logic                   aligned;
  logic [DW-1:0]          ctrl_q;
  logic [4:0]             mask_q;
  logic [NSRC-1:0]        en_q, type_q, force_q;
  logic [NSRC*PRIO_W-1:0] prio_q;
  logic [NSRC-1:0]        pend, npend, fpend;
  logic                   n_valid, f_valid, n_pass, n_hit;
  logic [IDX_W-1:0]       n_idx, f_idx;
  logic [PRIO_W-1:0]      n_prio;
  logic [DW-1:0]          nvec, fvec, rd_mux;

  assign word    = addr_i[6:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  irq_vic_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i && aligned),
    .word_i  (word),
    .wdata_i (wdata_i),
    .ctrl_o  (ctrl_q),
    .mask_o  (mask_q),
    .en_o    (en_q),
    .type_o  (type_q),
    .force_o (force_q),
    .prio_o  (prio_q)
  );

  assign pend  = (src_i | force_q) & en_q;
  assign npend = pend & ~type_q;
  assign fpend = pend & type_q;

  irq_vic_arb #(.N(NSRC), .PW(PRIO_W)) u_narb (
    .req_i   (npend),
    .prio_i  (prio_q),
    .valid_o (n_valid),
    .idx_o   (n_idx),
    .prio_o  (n_prio)
  );

  irq_vic_hipick #(.N(NSRC)) u_fpick (
    .req_i   (fpend),
    .valid_o (f_valid),
    .idx_o   (f_idx)
  );

  // threshold bit 4 set disables masking
  assign n_pass = mask_q[4] || (n_prio > mask_q[PRIO_W-1:0]);
  assign n_hit  = n_valid && n_pass;
  assign nirq_o = n_hit;
  assign firq_o = |fpend;

  assign nvec = n_hit   ? {{VPAD{1'b0}}, n_idx, {PPAD{1'b0}}, n_prio} : {NO_VEC, 16'h0};
  assign fvec = f_valid ? {{VPAD{1'b0}}, f_idx, 16'h0}                : {NO_VEC, 16'h0};

  always_comb begin
    rd_mux = '0;
    case (word)
      W_CTRL: rd_mux = ctrl_q;
      W_MASK: rd_mux = {27'h0, mask_q};
      W_ENH:  rd_mux = en_q[NSRC-1:HALF];
      W_ENL:  rd_mux = en_q[HALF-1:0];
      W_TYPH: rd_mux = type_q[NSRC-1:HALF];
      W_TYPL: rd_mux = type_q[HALF-1:0];
      W_NVEC: rd_mux = nvec;
      W_FVEC: rd_mux = fvec;
      W_SRCH: rd_mux = src_i[NSRC-1:HALF];
      W_SRCL: rd_mux = src_i[HALF-1:0];
      W_FRCH: rd_mux = force_q[NSRC-1:HALF];
      W_FRCL: rd_mux = force_q[HALF-1:0];
      W_NPH:  rd_mux = npend[NSRC-1:HALF];
      W_NPL:  rd_mux = npend[HALF-1:0];
      W_FPH:  rd_mux = fpend[NSRC-1:HALF];
      W_FPL:  rd_mux = fpend[HALF-1:0];
      default: begin
        for (int r = 0; r < NPRIO_R; r++)
          if (word == word_t'(W_PRITOP - r)) rd_mux = prio_q[r*DW +: DW];
      end
    endcase
  end

  assign rdata_o = (rd_en_i && aligned) ? rd_mux : '0;
endmodule

// File: rtl/irq_vic_chk.sv
module irq_vic_chk
  import irq_vic_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic [6:0]      addr_i,
  input logic [DW-1:0]   wdata_i,
  input logic [NSRC-1:0] src_i,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] type_q,
  input logic [NSRC-1:0] force_q,
  input logic            nirq_o,
  input logic            firq_o
);
  logic ennum_wr, disnum_wr;
  assign ennum_wr  = wr_en_i && addr_i == 7'h08;
  assign disnum_wr = wr_en_i && addr_i == 7'h0C;

  p_ennum_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ennum_wr |=> (en_q & (64'd1 << $past(wdata_i[IDX_W-1:0]))) != 64'd0);

  p_disnum_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disnum_wr |=> (en_q & (64'd1 << $past(wdata_i[IDX_W-1:0]))) == 64'd0);

  p_ennum_only_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ennum_wr |=> (en_q | (64'd1 << $past(wdata_i[IDX_W-1:0])))
              == ($past(en_q) | (64'd1 << $past(wdata_i[IDX_W-1:0]))));

  p_firq_needs_route_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    firq_o |-> (type_q & en_q) != 64'd0);

  p_nirq_needs_norm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nirq_o |-> ((src_i | force_q) & en_q & ~type_q) != 64'd0);

  p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == 64'd0) |-> (!nirq_o && !firq_o));
endmodule

bind irq_vic irq_vic_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .src_i   (src_i),
  .en_q    (en_q),
  .type_q  (type_q),
  .force_q (force_q),
  .nirq_o  (nirq_o),
  .firq_o  (firq_o)
);

// File: tb/tb_irq_vic.sv
`timescale 1ns/1ps
module tb_irq_vic;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [6:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [63:0] src_i = '0;
  logic        nirq_o, firq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  irq_vic dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .src_i(src_i), .nirq_o(nirq_o), .firq_o(firq_o)
  );

  // {is_write, offset, data, expected, requirement}
  localparam int NV = 37;
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 8'h04, 32'h0, 32'h0000_001F, 4'd1},  // R1 threshold reset
    {1'b0, 8'h40, 32'h0, 32'hFFFF_0000, 4'd7},  // R7 nothing pending
    {1'b0, 8'h44, 32'h0, 32'hFFFF_0000, 4'd9},  // R9 nothing pending
    {1'b1, 8'h14, 32'h0000_0003, 32'h0, 4'd2},
    {1'b1, 8'h54, 32'h0000_0001, 32'h0, 4'd4},
    {1'b0, 8'h5C, 32'h0, 32'h0000_0001, 4'd4},  // R4 forced line pending
    {1'b0, 8'h40, 32'h0, 32'h0000_0000, 4'd7},
    {1'b1, 8'h3C, 32'h0000_0050, 32'h0, 4'd6},  // R6 word 0, line 1
    {1'b1, 8'h54, 32'h0000_0003, 32'h0, 4'd4},
    {1'b0, 8'h40, 32'h0, 32'h0001_0005, 4'd7},
    {1'b1, 8'h3C, 32'h0000_0055, 32'h0, 4'd6},
    {1'b0, 8'h40, 32'h0, 32'h0001_0005, 4'd7},  // R7 tie -> higher number
    {1'b1, 8'h08, 32'h0000_0028, 32'h0, 4'd3},  // R3 enable line 40
    {1'b1, 8'h50, 32'h0000_0100, 32'h0, 4'd2},
    {1'b1, 8'h28, 32'h0000_0007, 32'h0, 4'd6},  // R6 word 5 at 0x28
    {1'b0, 8'h40, 32'h0, 32'h0028_0007, 4'd6},
    {1'b0, 8'h10, 32'h0, 32'h0000_0100, 4'd2},  // R2 high enable word
    {1'b0, 8'h58, 32'h0, 32'h0000_0100, 4'd2},
    {1'b1, 8'h04, 32'h0000_0007, 32'h0, 4'd8},
    {1'b0, 8'h40, 32'h0, 32'hFFFF_0000, 4'd8},  // R8 equal -> masked
    {1'b1, 8'h04, 32'h0000_0006, 32'h0, 4'd8},
    {1'b0, 8'h40, 32'h0, 32'h0028_0007, 4'd8},  // R8 above -> passes
    {1'b1, 8'h04, 32'h0000_001F, 32'h0, 4'd8},
    {1'b1, 8'h18, 32'h0000_0100, 32'h0, 4'd5},  // R5 route line 40 fast
    {1'b0, 8'h60, 32'h0, 32'h0000_0100, 4'd5},
    {1'b0, 8'h44, 32'h0, 32'h0028_0000, 4'd9},
    {1'b0, 8'h40, 32'h0, 32'h0001_0005, 4'd5},
    {1'b0, 8'h58, 32'h0, 32'h0000_0000, 4'd4},
    {1'b1, 8'h0C, 32'h0000_0028, 32'h0, 4'd3},  // R3 acknowledge line 40
    {1'b0, 8'h44, 32'h0, 32'hFFFF_0000, 4'd3},
    {1'b0, 8'h10, 32'h0, 32'h0000_0000, 4'd3},
    {1'b0, 8'h14, 32'h0, 32'h0000_0003, 4'd3},  // R3 neighbours untouched
    {1'b1, 8'h00, 32'hA5A5_1234, 32'h0, 4'd11},
    {1'b0, 8'h00, 32'h0, 32'hA5A5_1234, 4'd11}, // R11 control readback
    {1'b1, 8'h4C, 32'hFFFF_FFFF, 32'h0, 4'd11},
    {1'b0, 8'h4C, 32'h0, 32'h0000_0000, 4'd11}, // R11 read-only ignored
    {1'b0, 8'h50, 32'h0, 32'h0000_0100, 4'd2}
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a[6:0]; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk_i);
    addr_i = a[6:0]; rd_en_i = 1'b1;
    #1 chk(req, rdata_o, exp);
    rd_en_i = 1'b0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    #1 chk(1, {31'h0, nirq_o}, 32'h0);
    chk(1, {31'h0, firq_o}, 32'h0);
    rd(1, 8'h00, 32'h0);
    rd(1, 8'h14, 32'h0);
    rd(1, 8'h18, 32'h0);
    rd(1, 8'h3C, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) wr(VEC[i][75:68], VEC[i][67:36]);
      else            rd(int'(VEC[i][3:0]), VEC[i][75:68], VEC[i][35:4]);
    end

    // R10 normal request follows the vector
    @(negedge clk_i); #1;
    chk(10, {31'h0, nirq_o}, 32'h1);
    chk(5, {31'h0, firq_o}, 32'h0);

    // R4 raw level on line 63, priority in word 7 at 0x20
    src_i[63] = 1'b1;
    wr(8'h08, 32'd63);
    wr(8'h20, 32'hF000_0000);
    rd(2, 8'h48, 32'h8000_0000);
    rd(7, 8'h40, 32'h003F_000F);
    src_i[63] = 1'b0;
    rd(4, 8'h40, 32'h0001_0005);

    // R5 / R10 route lines 0,1 fast
    wr(8'h1C, 32'h0000_0003);
    #1;
    chk(10, {31'h0, nirq_o}, 32'h0);
    chk(5, {31'h0, firq_o}, 32'h1);
    rd(9, 8'h44, 32'h0001_0000);
    rd(10, 8'h40, 32'hFFFF_0000);

    // R3 acknowledge by disable-by-number
    wr(8'h0C, 32'd1);
    wr(8'h0C, 32'd0);
    #1 chk(3, {31'h0, firq_o}, 32'h0);

    // R11 misaligned, strobe low
    rd(11, 8'h41, 32'h0);
    wr(8'h01, 32'h0000_0000);
    rd(11, 8'h04, 32'h0000_001F);
    @(negedge clk_i); addr_i = 7'h00; rd_en_i = 1'b0;
    #1 chk(11, rdata_o, 32'h0);

    // R1 reset after activity
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    rd(1, 8'h1C, 32'h0);
    rd(1, 8'h04, 32'h0000_001F);
    rd(1, 8'h3C, 32'h0);
    rd(1, 8'h54, 32'h0);

    summary();
  end
endmodule